// File: doc/BRIEF.md
# USB Low/Full-Speed Line State Monitor

This block watches the two synchronized single-ended receiver outputs of a USB data pair. On every clock it classifies the pair as single-ended zero, single-ended one, J or K, and it turns timed runs of those states into one-cycle event pulses. The events are start of packet, end of packet, resume from suspend, disconnect, connect and bus reset. A speed input selects which differential polarity counts as J. Everything is timed in cycles of a clock of known frequency.

The decoded state is registered, so it appears one clock after the pair is sampled. Each timer measures how long the current decoded state has been held. The timer restarts whenever the decoded state changes. The clock rate in MHz, the reset threshold in microseconds and the bit time in clocks for each speed are parameters. The disconnect and connect thresholds are derived from the clock rate.

Top module: `usb_line_monitor`

## Requirements
- R1: With `low_speed` low, a sample of D+ high and D- low decodes to J (`line_state` = 2'b01), and D+ low with D- high decodes to K (2'b10). The decode appears one clock after the sample.
- R2: With `low_speed` high, the differential mapping is swapped: D+ low with D- high is J (2'b01), and D+ high with D- low is K (2'b10).
- R3: Both lines low decodes to SE0 (2'b00). Both lines high decodes to SE1 (2'b11), and `se1_err` is high while SE1 is shown.
- R4: When `suspend` is low, `sop` pulses in the first cycle that K is shown, provided the state shown just before was J.
- R5: `eop` pulses when J has been shown for one bit time (FS_BIT_CLKS or LS_BIT_CLKS clocks, chosen by `low_speed`), provided the run just before that J was an SE0 run lasting at least one bit time.
- R6: When `suspend` is high, `resume` pulses in the first cycle that K is shown, following any other state. In that case `sop` stays low.
- R7: `disconnect` pulses in the cycle in which SE0 has been shown for 2.5 µs (CLK_MHZ*5/2 clocks).
- R8: After a disconnect, and also after reset, `connect` pulses in the first cycle after a J run ends. The J run must have lasted at least 2.5 µs and no more than 2.0 ms (CLK_MHZ*2000 clocks). A connect clears this condition until the next disconnect.
- R9: `bus_reset` pulses in the cycle in which SE0 has been shown for RESET_US microseconds (CLK_MHZ*RESET_US clocks).
- R10: Every event output is high for at most one cycle at a time. After reset all event outputs are low and `line_state` shows SE0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock, CLK_MHZ MHz |
| rst_n | input | 1 | Active-low synchronous reset |
| dp_rx | input | 1 | Synchronized D+ single-ended receiver output |
| dm_rx | input | 1 | Synchronized D- single-ended receiver output |
| low_speed | input | 1 | High selects the low-speed J/K mapping and bit time |
| suspend | input | 1 | High while the port is suspended; K then means resume |
| line_state | output | 2 | Decoded state: 00 SE0, 01 J, 10 K, 11 SE1 |
| se1_err | output | 1 | High while the invalid SE1 state is shown |
| sop | output | 1 | Start-of-packet pulse |
| eop | output | 1 | End-of-packet pulse |
| resume | output | 1 | Resume pulse |
| disconnect | output | 1 | Disconnect pulse |
| connect | output | 1 | Connect pulse |
| bus_reset | output | 1 | Bus reset pulse |

## Verification
The decoded state, `sop`, `resume` and `connect` follow the sampled pair by exactly one clock. `disconnect`, `bus_reset` and `eop` rise in the N-th cycle that the relevant state is shown, where N is the threshold in clocks. The bench drives inputs just after a rising edge. A behavioural model updates on the same edge and keeps the run length as a plain integer. Every output is compared with the model at the falling edge, so each result is checked in exactly the cycle it is due and in no other.

// File: rtl/usb_line_monitor.sv
module usb_line_monitor #(
  parameter int CLK_MHZ     = 144,
  parameter int RESET_US    = 5000,
  parameter int FS_BIT_CLKS = 12,
  parameter int LS_BIT_CLKS = 96
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dp_rx,
  input  logic       dm_rx,
  input  logic       low_speed,
  input  logic       suspend,
  output logic [1:0] line_state,
  output logic       se1_err,
  output logic       sop,
  output logic       eop,
  output logic       resume,
  output logic       disconnect,
  output logic       connect,
  output logic       bus_reset
);
  localparam int T_DISC = CLK_MHZ * 5 / 2;
  localparam int T_CONN = CLK_MHZ * 2000;
  localparam int T_RST  = CLK_MHZ * RESET_US;
  localparam int T_TOP  = ((T_CONN > T_RST) ? T_CONN : T_RST) + 1;
  localparam int CW     = $clog2(T_TOP + 1);

  localparam logic [CW-1:0] C_DISC = CW'(T_DISC);
  localparam logic [CW-1:0] C_CONN = CW'(T_CONN);
  localparam logic [CW-1:0] C_RST  = CW'(T_RST);
  localparam logic [CW-1:0] C_TOP  = CW'(T_TOP);
  localparam logic [CW-1:0] C_FS   = CW'(FS_BIT_CLKS);
  localparam logic [CW-1:0] C_LS   = CW'(LS_BIT_CLKS);

  localparam logic [1:0] ST_SE0 = 2'b00;
  localparam logic [1:0] ST_J   = 2'b01;
  localparam logic [1:0] ST_K   = 2'b10;
  localparam logic [1:0] ST_SE1 = 2'b11;

  logic [1:0]    cur, state_q;
  logic [CW-1:0] cnt_q;
  logic          arm_q, offline_q, sop_q, resume_q, connect_q;

  always_comb begin
    case ({dp_rx, dm_rx})
      2'b00:   cur = ST_SE0;
      2'b11:   cur = ST_SE1;
      2'b10:   cur = low_speed ? ST_K : ST_J;
      default: cur = low_speed ? ST_J : ST_K;
    endcase
  end

  wire           changed = cur != state_q;
  wire [CW-1:0]  bit_len = low_speed ? C_LS : C_FS;
  wire           conn_ok = offline_q && state_q == ST_J &&
                           cnt_q >= C_DISC && cnt_q <= C_CONN;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_SE0;
      cnt_q     <= '0;
      arm_q     <= 1'b0;
      offline_q <= 1'b1;
      sop_q     <= 1'b0;
      resume_q  <= 1'b0;
      connect_q <= 1'b0;
    end else begin
      state_q   <= cur;
      sop_q     <= changed && state_q == ST_J && cur == ST_K && !suspend;
      resume_q  <= changed && cur == ST_K && suspend;
      connect_q <= changed && conn_ok;
      if (changed) begin
        cnt_q <= CW'(1);
        arm_q <= state_q == ST_SE0 && cur == ST_J && cnt_q >= bit_len;
      end else if (cnt_q != C_TOP) begin
        cnt_q <= cnt_q + CW'(1);
      end
      if (disconnect)
        offline_q <= 1'b1;
      else if (changed && conn_ok)
        offline_q <= 1'b0;
    end
  end

  assign line_state = state_q;
  assign se1_err    = state_q == ST_SE1;
  assign sop        = sop_q;
  assign resume     = resume_q;
  assign connect    = connect_q;
  assign disconnect = state_q == ST_SE0 && cnt_q == C_DISC;
  assign bus_reset  = state_q == ST_SE0 && cnt_q == C_RST;
  assign eop        = arm_q && state_q == ST_J && cnt_q == bit_len;
endmodule

module usb_line_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dp_rx,
  input logic       dm_rx,
  input logic       low_speed,
  input logic       suspend,
  input logic [1:0] line_state,
  input logic       se1_err,
  input logic       sop,
  input logic       eop,
  input logic       resume,
  input logic       disconnect,
  input logic       connect,
  input logic       bus_reset
);
  assert_fs_j_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_rx && !dm_rx && !low_speed) |=> line_state == 2'b01);
  assert_ls_j_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!dp_rx && dm_rx && low_speed) |=> line_state == 2'b01);
  assert_se1_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_rx && dm_rx) |=> se1_err);
  assert_sop_from_j_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sop |-> line_state == 2'b10 && $past(line_state) == 2'b01 && !$past(suspend));
  assert_eop_on_j_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eop |-> line_state == 2'b01);
  assert_resume_k_R6: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> $past(suspend) && line_state == 2'b10 && !sop);
  assert_disc_se0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    disconnect |-> line_state == 2'b00 && $past(line_state) == 2'b00);
  assert_conn_after_j_R8: assert property (@(posedge clk) disable iff (!rst_n)
    connect |-> $past(line_state) == 2'b01 && line_state != 2'b01);
  assert_reset_se0_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |-> line_state == 2'b00);
  assert_sop_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sop |=> !sop);
  assert_eop_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eop |=> !eop);
  assert_disc_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    disconnect |=> !disconnect);
  assert_conn_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    connect |=> !connect);
endmodule

bind usb_line_monitor usb_line_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dp_rx(dp_rx), .dm_rx(dm_rx),
  .low_speed(low_speed), .suspend(suspend), .line_state(line_state),
  .se1_err(se1_err), .sop(sop), .eop(eop), .resume(resume),
  .disconnect(disconnect), .connect(connect), .bus_reset(bus_reset)
);

// File: tb/tb_usb_line_monitor.sv
module tb_usb_line_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int MHZ = 4;
  localparam int RUS = 50;
  localparam int FSB = 3;
  localparam int LSB = 8;
  localparam int TD  = MHZ * 5 / 2;
  localparam int TC  = MHZ * 2000;
  localparam int TR  = MHZ * RUS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dp_rx = 1'b0, dm_rx = 1'b0, low_speed = 1'b0, suspend = 1'b0;
  logic [1:0] line_state;
  logic se1_err, sop, eop, resume, disconnect, connect, bus_reset;

  usb_line_monitor #(.CLK_MHZ(MHZ), .RESET_US(RUS), .FS_BIT_CLKS(FSB),
                     .LS_BIT_CLKS(LSB)) dut (
    .clk(clk), .rst_n(rst_n), .dp_rx(dp_rx), .dm_rx(dm_rx),
    .low_speed(low_speed), .suspend(suspend), .line_state(line_state),
    .se1_err(se1_err), .sop(sop), .eop(eop), .resume(resume),
    .disconnect(disconnect), .connect(connect), .bus_reset(bus_reset));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference
  logic [1:0] m_st;
  int run;
  bit m_arm, m_off, m_sop, m_res, m_con;

  function automatic logic [1:0] decode(logic p, logic m, logic ls);
    if (p == m) return p ? 2'b11 : 2'b00;
    if (p ^ ls) return 2'b01;
    return 2'b10;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 2'b00; run = 0; m_arm = 0; m_off = 1;
      m_sop = 0; m_res = 0; m_con = 0;
    end else begin
      logic [1:0] nx;
      bit was_disc;
      int bl;
      nx = decode(dp_rx, dm_rx, low_speed);
      bl = low_speed ? LSB : FSB;
      was_disc = (m_st == 2'b00) && (run == TD);
      if (nx != m_st) begin
        m_sop = (m_st == 2'b01) && (nx == 2'b10) && !suspend;
        m_res = suspend && (nx == 2'b10);
        m_con = m_off && (m_st == 2'b01) && run >= TD && run <= TC;
        m_arm = (m_st == 2'b00) && (nx == 2'b01) && run >= bl;
        run = 1;
      end else begin
        m_sop = 0; m_res = 0; m_con = 0;
        run++;
      end
      if (was_disc) m_off = 1;
      else if (m_con) m_off = 0;
      m_st = nx;
    end
  end

  task automatic chk(input bit got, input bit want, input string tag);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, got, want, $time);
    end
  endtask

  logic p_sop = 0, p_eop = 0, p_res = 0, p_dis = 0, p_con = 0, p_rst = 0;

  always @(negedge clk) begin
    if (!done) begin
      int bl;
      bl = low_speed ? LSB : FSB;
      checks++;
      if (line_state !== m_st) begin
        errors++;
        $display("FAIL %s line_state: actual=%0d expected=%0d at %0t",
                 low_speed ? "R2" : "R1", line_state, m_st, $time);
      end
      chk(se1_err, m_st == 2'b11, "R3 se1_err");
      chk(sop, m_sop, "R4 sop");
      chk(eop, m_arm && m_st == 2'b01 && run == bl, "R5 eop");
      chk(resume, m_res, "R6 resume");
      chk(disconnect, m_st == 2'b00 && run == TD, "R7 disconnect");
      chk(connect, m_con, "R8 connect");
      chk(bus_reset, m_st == 2'b00 && run == TR, "R9 bus_reset");
      chk((p_sop & sop) | (p_eop & eop) | (p_res & resume) | (p_dis & disconnect) |
          (p_con & connect) | (p_rst & bus_reset), 1'b0, "R10 pulse width");
      p_sop = sop; p_eop = eop; p_res = resume;
      p_dis = disconnect; p_con = connect; p_rst = bus_reset;
    end
  end

  task automatic hold(input logic p, input logic m, input int n);
    dp_rx = p; dm_rx = m;
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    // full speed: disconnect, idle, connect with start of packet
    hold(0, 0, 20);
    hold(1, 0, 30);
    hold(0, 1, 2);
    hold(1, 0, 3); hold(0, 1, 3); hold(1, 0, 1); hold(0, 1, 2);
    // valid end of packet, then an SE0 too short for one
    hold(0, 0, 6); hold(1, 0, 10);
    hold(0, 1, 3); hold(0, 0, 2); hold(1, 0, 10);
    // invalid SE1
    hold(1, 1, 3); hold(1, 0, 4);
    // long SE0: disconnect then bus reset
    hold(0, 0, 250);
    // idle beyond the connect window, then one inside it
    hold(1, 0, TC + 100); hold(0, 1, 3);
    hold(0, 0, 15); hold(1, 0, 20); hold(0, 1, 3);
    // suspended: K means resume
    suspend = 1'b1;
    hold(1, 0, 5); hold(0, 1, 4); hold(0, 0, 3); hold(0, 1, 3); hold(1, 0, 5);
    suspend = 1'b0;
    // low speed mapping and bit time
    low_speed = 1'b1;
    hold(0, 1, 20); hold(1, 0, 3); hold(0, 1, 5);
    hold(0, 0, 16); hold(0, 1, 12);
    hold(0, 0, 9); hold(0, 1, 10);
    hold(0, 0, 4); hold(0, 1, 12);
    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule